// File: doc/BRIEF.md
# Ethernet PHY Management Register Bank

This block holds a handful of Ethernet PHY management registers behind a plain parallel register port. A host presents a 5-bit register number with either a write strobe and 16 bits of data, or a read strobe. Read data is registered: it appears after the clock edge that samples the read strobe, and it holds there until the next read.

Three kinds of register live here. A status register at address 1 reports two sticky events taken from live inputs, and a constant capability flag. The link flag latches low. Once the link drops, the flag stays at 0 until the status register is read. The jabber flag latches high and survives until a read finds the jabber condition gone. Addresses 2 and 3 return fixed identifier words. Address 4 holds the autonegotiation advertisement word. Software can write it, except for bits that are forced to zero, and it resets to a pattern set by a parameter.

Reading the status register both returns the latched events and releases them. The value returned is always the one held before that read's own update.

Top module: `phy_mgmt_regs`

## Requirements
- R1: While reset is asserted and after it is released, rd_data is 16'h0000. Both latched status flags reset to 0, so the first status read after reset returns 16'h0001.
- R2: Link flag (status bit 2): when link_up is 0 at a clock edge, the flag becomes 0. It stays 0 across later edges with link_up at 1 until the status register is read.
- R3: A status read returns the flags held before that edge. At that edge the link flag is loaded with the current link_up, so a link loss in the read cycle leaves it at 0.
- R4: Jabber flag (status bit 1): jabber_det at 1 at an edge sets it. A status read clears it only when jabber_det is 0 at that read's edge.
- R5: Status bit 0 always reads 1, and status bits 15:3 always read 0.
- R6: Address 2 reads 16'h0180. Address 3 reads 16'h7783, which packs 6'h1D in bits 15:10, model 6'h38 in bits 9:4 and revision 4'h3 in bits 3:0.
- R7: Reset loads address 4 with selector 5'b00001 in bits 4:0 and the ability parameter in bits 10:5, with bit 9 forced to 0. With the default parameter this gives 16'h05E1.
- R8: A write to address 4 stores the data with bits 12, 11 and 9 forced to 0. All other bits take the written value.
- R9: Reads of addresses 0 and 5 to 31 return 16'h0000. Writes to addresses other than 4 change no register.
- R10: rd_data updates only at an edge that samples rd_en at 1, and holds otherwise. When a read and a write of address 4 fall in the same cycle, the read returns the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 5 | Register number for this cycle's access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Registered read data |
| link_up | input | 1 | Live link-good indication |
| jabber_det | input | 1 | Live jabber-condition indication |

## Verification
Each result is due exactly one edge after its cause. Read data, flag updates and advertisement writes all land at the edge that samples the strobe or input, so a write is visible to a read issued in the following cycle. The bench drives each stimulus vector at a falling edge. It compares rd_data at the next falling edge, half a period after the sampling rising edge. It then drives the next vector. This lets sticky-flag sequences such as a loss, a recovery and then a read be expressed as consecutive one-cycle vectors with known expected words.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int REG_AW = 5;
  localparam int REG_DW = 16;

  localparam logic [REG_AW-1:0] ADDR_STATUS = 5'd1;
  localparam logic [REG_AW-1:0] ADDR_ID_HI  = 5'd2;
  localparam logic [REG_AW-1:0] ADDR_ID_LO  = 5'd3;
  localparam logic [REG_AW-1:0] ADDR_ADV    = 5'd4;

  // bits 12:11 reserved, bit 9 (T4 ability) must stay low
  localparam logic [REG_DW-1:0] ADV_KEEP_MASK = 16'hE5FF;
  localparam logic [4:0]        ADV_SELECTOR  = 5'b00001;

  function automatic logic [REG_DW-1:0] pack_status(input logic lnk, input logic jab);
    return {13'd0, lnk, jab, 1'b1};
  endfunction

  function automatic logic [REG_DW-1:0] pack_id_lo(input logic [5:0] oui_tail,
                                                    input logic [5:0] model,
                                                    input logic [3:0] rev);
    return {oui_tail, model, rev};
  endfunction

  function automatic logic [REG_DW-1:0] adv_filter(input logic [REG_DW-1:0] d);
    return d & ADV_KEEP_MASK;
  endfunction

  function automatic logic [REG_DW-1:0] adv_reset_word(input logic [5:0] abil);
    return adv_filter({5'd0, abil, ADV_SELECTOR});
  endfunction
endpackage

// File: rtl/phy_stat_latch.sv
module phy_stat_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic link_up,
  input  logic jabber_det,
  input  logic clr_evt,
  output logic lnk_q,
  output logic jab_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lnk_q <= 1'b0;
      jab_q <= 1'b0;
    end else begin
      // a read reloads from the live link; otherwise only falls
      lnk_q <= clr_evt ? link_up : (lnk_q & link_up);
      jab_q <= jabber_det | (jab_q & ~clr_evt);
    end
  end
endmodule

// File: rtl/phy_adv_reg.sv
module phy_adv_reg
  import phy_mgmt_pkg::*;
#(
  parameter logic [5:0] RST_ABIL = 6'b101111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [REG_DW-1:0] wr_data,
  output logic [REG_DW-1:0] adv_q
);
  localparam logic [REG_DW-1:0] RST_WORD = adv_reset_word(RST_ABIL);

  always_ff @(posedge clk) begin
    if (!rst_n)      adv_q <= RST_WORD;
    else if (wr_hit) adv_q <= adv_filter(wr_data);
  end
endmodule

// File: rtl/phy_rd_mux.sv
module phy_rd_mux
  import phy_mgmt_pkg::*;
(
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] status_word,
  input  logic [REG_DW-1:0] id_hi_word,
  input  logic [REG_DW-1:0] id_lo_word,
  input  logic [REG_DW-1:0] adv_word,
  output logic [REG_DW-1:0] rd_word
);
  always_comb begin
    unique case (addr)
      ADDR_STATUS: rd_word = status_word;
      ADDR_ID_HI:  rd_word = id_hi_word;
      ADDR_ID_LO:  rd_word = id_lo_word;
      ADDR_ADV:    rd_word = adv_word;
      default:     rd_word = '0;
    endcase
  end
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter logic [15:0] ID_HI     = 16'h0180,
  parameter logic [5:0]  OUI_TAIL  = 6'h1D,
  parameter logic [5:0]  MODEL_NUM = 6'h38,
  parameter logic [3:0]  REV_NUM   = 4'h3,
  parameter logic [5:0]  ADV_ABIL  = 6'b101111
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  reg_addr,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic        rd_en,
  output logic [15:0] rd_data,
  input  logic        link_up,
  input  logic        jabber_det
);
  localparam logic [REG_DW-1:0] ID_LO = pack_id_lo(OUI_TAIL, MODEL_NUM, REV_NUM);

  // named internal events for the checker
  logic              status_rd_evt;
  logic              adv_wr_evt;
  logic              lnk_q, jab_q;
  logic [REG_DW-1:0] adv_q;
  logic [REG_DW-1:0] rd_word;

  assign status_rd_evt = rd_en & (reg_addr == ADDR_STATUS);
  assign adv_wr_evt    = wr_en & (reg_addr == ADDR_ADV);

  phy_stat_latch i_stat (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .jabber_det(jabber_det),
    .clr_evt(status_rd_evt), .lnk_q(lnk_q), .jab_q(jab_q)
  );

  phy_adv_reg #(.RST_ABIL(ADV_ABIL)) i_adv (
    .clk(clk), .rst_n(rst_n), .wr_hit(adv_wr_evt), .wr_data(wr_data), .adv_q(adv_q)
  );

  phy_rd_mux i_mux (
    .addr(reg_addr), .status_word(pack_status(lnk_q, jab_q)),
    .id_hi_word(ID_HI), .id_lo_word(ID_LO), .adv_word(adv_q), .rd_word(rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_word;
  end
endmodule

// File: rtl/phy_mgmt_regs_chk.sv
module phy_mgmt_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_en,
  input logic [4:0]  reg_addr,
  input logic        link_up,
  input logic        jabber_det,
  input logic [15:0] rd_data,
  input logic        status_rd_evt,
  input logic        lnk_q,
  input logic        jab_q,
  input logic [15:0] adv_q
);
  a_r1_reset_rd: assert property (@(posedge clk) !rst_n |=> rd_data == 16'h0000);
  a_r2_link_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!lnk_q && !status_rd_evt) |=> !lnk_q);
  a_r3_read_reload: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd_evt |=> lnk_q == $past(link_up));
  a_r4_jab_set: assert property (@(posedge clk) disable iff (!rst_n)
    jabber_det |=> jab_q);
  a_r4_jab_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (jab_q && !status_rd_evt) |=> jab_q);
  a_r5_status_const: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_addr == 5'd1) |=> (rd_data[0] && rd_data[15:3] == 13'd0));
  a_r8_adv_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_q[12:11] == 2'b00) && !adv_q[9]);
  a_r9_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (reg_addr == 5'd0 || reg_addr > 5'd4)) |=> rd_data == 16'h0000);
  a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

bind phy_mgmt_regs phy_mgmt_regs_chk i_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .reg_addr(reg_addr),
  .link_up(link_up), .jabber_det(jabber_det), .rd_data(rd_data),
  .status_rd_evt(status_rd_evt), .lnk_q(lnk_q), .jab_q(jab_q), .adv_q(adv_q)
);

// File: tb/test_phy_mgmt_regs.sv
module test_phy_mgmt_regs;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        link_up = 1'b1;
  logic        jabber_det = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_mgmt_regs i_phy_mgmt_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .link_up(link_up), .jabber_det(jabber_det)
  );

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic [4:0]  addr;
    logic [15:0] wdata;
    logic        lnk;
    logic        jab;
    logic        chk;
    logic [3:0]  req;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,5'd1,16'h0000,1'b1,1'b0,1'b1,4'd1, 16'h0001}, // R1 first status read
    '{1'b0,1'b1,5'd1,16'h0000,1'b1,1'b0,1'b1,4'd3, 16'h0005}, // R3 reload to live link
    '{1'b0,1'b0,5'd0,16'h0000,1'b0,1'b0,1'b0,4'd2, 16'h0000}, // link lost
    '{1'b0,1'b0,5'd0,16'h0000,1'b1,1'b0,1'b0,4'd2, 16'h0000}, // link back
    '{1'b0,1'b1,5'd1,16'h0000,1'b1,1'b0,1'b1,4'd2, 16'h0001}, // R2 still latched low
    '{1'b0,1'b1,5'd1,16'h0000,1'b1,1'b0,1'b1,4'd3, 16'h0005},
    '{1'b0,1'b1,5'd1,16'h0000,1'b0,1'b0,1'b1,4'd3, 16'h0005}, // R3 old value, loss at read
    '{1'b0,1'b1,5'd1,16'h0000,1'b1,1'b0,1'b1,4'd3, 16'h0001}, // R3 loss at read kept 0
    '{1'b0,1'b0,5'd0,16'h0000,1'b1,1'b1,1'b0,4'd4, 16'h0000}, // jabber pulse
    '{1'b0,1'b0,5'd0,16'h0000,1'b1,1'b0,1'b0,4'd4, 16'h0000},
    '{1'b0,1'b1,5'd1,16'h0000,1'b1,1'b1,1'b1,4'd4, 16'h0007}, // R4 read with jabber present
    '{1'b0,1'b1,5'd1,16'h0000,1'b1,1'b0,1'b1,4'd4, 16'h0007}, // R4 survived
    '{1'b0,1'b1,5'd1,16'h0000,1'b1,1'b0,1'b1,4'd4, 16'h0005}, // R4 cleared
    '{1'b0,1'b1,5'd2,16'h0000,1'b1,1'b0,1'b1,4'd6, 16'h0180}, // R6
    '{1'b0,1'b1,5'd3,16'h0000,1'b1,1'b0,1'b1,4'd6, 16'h7783}, // R6
    '{1'b0,1'b1,5'd4,16'h0000,1'b1,1'b0,1'b1,4'd7, 16'h05E1}, // R7
    '{1'b1,1'b0,5'd4,16'hFFFF,1'b1,1'b0,1'b0,4'd8, 16'h0000},
    '{1'b0,1'b1,5'd4,16'h0000,1'b1,1'b0,1'b1,4'd8, 16'hE5FF}, // R8 all ones masked
    '{1'b1,1'b0,5'd4,16'h1A00,1'b1,1'b0,1'b0,4'd8, 16'h0000},
    '{1'b0,1'b1,5'd4,16'h0000,1'b1,1'b0,1'b1,4'd8, 16'h0000}, // R8 only forced bits written
    '{1'b1,1'b0,5'd4,16'hA4A2,1'b1,1'b0,1'b0,4'd8, 16'h0000},
    '{1'b0,1'b1,5'd4,16'h0000,1'b1,1'b0,1'b1,4'd8, 16'hA4A2}, // R8 mixed pattern
    '{1'b1,1'b0,5'd2,16'h1234,1'b1,1'b0,1'b0,4'd9, 16'h0000},
    '{1'b1,1'b0,5'd1,16'hFFFF,1'b1,1'b0,1'b0,4'd9, 16'h0000},
    '{1'b1,1'b0,5'd9,16'hFFFF,1'b1,1'b0,1'b0,4'd9, 16'h0000},
    '{1'b0,1'b1,5'd2,16'h0000,1'b1,1'b0,1'b1,4'd9, 16'h0180}, // R9 id write ignored
    '{1'b0,1'b1,5'd1,16'h0000,1'b1,1'b0,1'b1,4'd9, 16'h0005}, // R9 status write ignored
    '{1'b0,1'b1,5'd0,16'h0000,1'b1,1'b0,1'b1,4'd9, 16'h0000}, // R9 unimplemented
    '{1'b0,1'b1,5'd31,16'h0000,1'b1,1'b0,1'b1,4'd9,16'h0000},
    '{1'b0,1'b1,5'd5,16'h0000,1'b1,1'b0,1'b1,4'd9, 16'h0000},
    '{1'b1,1'b1,5'd4,16'h0021,1'b1,1'b0,1'b1,4'd10,16'hA4A2}, // R10 read sees old word
    '{1'b0,1'b1,5'd4,16'h0000,1'b1,1'b0,1'b1,4'd10,16'h0021},
    '{1'b0,1'b0,5'd3,16'h0000,1'b1,1'b0,1'b1,4'd10,16'h0021}  // R10 hold without read
  };

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input int req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: rd_data=%h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic rd, input logic [4:0] a,
                       input logic [15:0] d, input logic l, input logic j);
    wr_en = wr; rd_en = rd; reg_addr = a; wr_data = d; link_up = l; jabber_det = j;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rd_data, 16'h0000, 1); // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_data, 16'h0000, 1); // R1 after release
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      drive(v.wr, v.rd, v.addr, v.wdata, v.lnk, v.jab);
      @(negedge clk);
      if (v.chk) check(rd_data, v.exp, int'(v.req));
    end
    // directed: reset mid-run restores advertisement and clears flags (R7, R1)
    drive(1'b1, 1'b0, 5'd4, 16'hFFFF, 1'b1, 1'b1);
    @(negedge clk);
    drive(1'b0, 1'b0, 5'd0, 16'h0, 1'b1, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    check(rd_data, 16'h0000, 1);
    rst_n = 1'b1;
    drive(1'b0, 1'b1, 5'd4, 16'h0, 1'b1, 1'b0);
    @(negedge clk);
    check(rd_data, 16'h05E1, 7);
    drive(1'b0, 1'b1, 5'd1, 16'h0, 1'b1, 1'b0);
    @(negedge clk);
    check(rd_data, 16'h0001, 1); // R1 flags cleared by reset
    // directed R5 / R2: persistent loss stays 0 over a read
    drive(1'b0, 1'b1, 5'd1, 16'h0, 1'b0, 1'b0);
    @(negedge clk);
    check(rd_data, 16'h0005, 5);
    drive(1'b0, 1'b1, 5'd1, 16'h0, 1'b0, 1'b0);
    @(negedge clk);
    check(rd_data, 16'h0001, 2);
    drive(1'b0, 1'b0, 5'd0, 16'h0, 1'b1, 1'b0);
    @(negedge clk);
    finish_run();
  end
endmodule